// File: doc/BRIEF.md
# Set/Clear Control and Sticky Status Register

This block holds the control word of a debug-probe front end and the sticky status flags that go with it, on a simple single-cycle memory-mapped bus. Software never writes the control word directly. It writes a mask to one of two offsets. At the set offset every 1 bit turns a control bit on. At the clear offset every 1 bit turns a control bit off. Bits written as 0 leave their control bits as they are, so two agents can change separate bits without a read-modify-write.

The control bits drive the target system reset, the TAP reset, the target power switch, two indicator LEDs and the selection of adaptive (returned-clock) TCK. Three sticky flags record events. Two come from external pins through a two-flop synchroniser: the target reset line seen low, and a power dropout. The third is a timeout pulse from the clock generator, which is already in this clock domain. Each flag is a two-state machine with the states FLAG_CLEAR and FLAG_HELD. It takes the transition *capture* (CLEAR to HELD) when its event is present, and it stays HELD without an event. The transition *rearm* loads the present event level, so the flag goes to HELD if the event is still present and to CLEAR if it is not. A read at the set offset returns the control bits merged with the flags.

Top module: `setclr_ctrl_status`

## Requirements
- R1: After reset (rst_n low) every control output is 0 and every sticky flag is clear, so a read at offset 0x10 returns 0.
- R2: A write at offset 0x10 sets each control bit whose data bit is 1 and leaves the control bits whose data bits are 0 unchanged.
- R3: A write at offset 0x14 clears each control bit whose data bit is 1 and leaves the control bits whose data bits are 0 unchanged.
- R4: Control bit 0 drives tgt_rst_o, bit 1 drives tap_rst_o, bit 3 drives tgt_pwr_en_o, bits 4 and 5 drive led_o[0] and led_o[1], and bit 8 drives adaptive_clk_sel_o. Each output follows the register from the clock edge that takes the write.
- R5: A read at offset 0x10 returns the control bits in positions 0, 1, 3, 4, 5 and 8 and the flags in positions 6, 7 and 10, with all other bits 0. A read at any other offset returns 0.
- R6: Bit 6 becomes 1 on the third rising clock edge after tgt_rst_sense_n_i goes low, and it stays 1 after the line returns high.
- R7: Bit 7 becomes 1 on the third rising clock edge after pwr_drop_i goes high, and it stays 1 after the input returns low.
- R8: Writing 1 to bit 6 or bit 7 at offset 0x10 rearms that flag. The flag then holds the present synchronised condition: 1 if the condition is still present, 0 if it is gone. A rearm write changes no control bit.
- R9: Bit 10 becomes 1 on the edge after rclk_timeout_i is high, and it stays 1 until a write at offset 0x14 with bit 10 set. If the timeout is present in the same cycle as that write, the flag stays 1.
- R10: Writes at other offsets, writes of bits 2, 9 and 11 to 31, writes of bit 10 at 0x10, and writes of bits 6 and 7 at 0x14 change no control output and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Read word for the offset on bus_addr (combinational) |
| tgt_rst_o | output | 1 | Asserts the target system reset |
| tap_rst_o | output | 1 | Asserts the TAP reset |
| tgt_pwr_en_o | output | 1 | Enables target power |
| led_o | output | 2 | Indicator LEDs |
| adaptive_clk_sel_o | output | 1 | Selects returned-clock TCK mode |
| tgt_rst_sense_n_i | input | 1 | Target reset line, asynchronous, low when asserted |
| pwr_drop_i | input | 1 | Power dropout sense, asynchronous, high on dropout |
| rclk_timeout_i | input | 1 | Returned-clock timeout pulse from the clock generator |

## Verification
Set and clear writes are made with masks that mix 1 and 0 bits over a word that already has some bits on. A register that is rewritten in full instead of masked therefore shows up as a wrong neighbouring bit. Sense inputs are sampled both one edge before and exactly at the synchroniser latency, which tells a missing or extra stage apart from a correct one. Rearm is tried with the condition gone and with it still present, so a flag that only clears fails the second case. The timeout clear is also issued in the same cycle as a new pulse, which separates a design where capture wins from one where clear wins.

// File: rtl/setclr_pkg.sv
package setclr_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam logic [ADDR_W-1:0] OFS_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR = 8'h14;

    // bit positions decoded by neighbouring logic
    localparam int B_TGT_RST  = 0;
    localparam int B_TAP_RST  = 1;
    localparam int B_PWR_EN   = 3;
    localparam int B_LED_A    = 4;
    localparam int B_LED_B    = 5;
    localparam int B_RST_SEEN = 6;
    localparam int B_PWR_DROP = 7;
    localparam int B_ADAPT    = 8;
    localparam int B_RCLK_TO  = 10;

    localparam int N_FLAGS    = 3;
    localparam int N_EXT      = 2;

    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << B_TGT_RST) | (DATA_W'(1) << B_TAP_RST) |
        (DATA_W'(1) << B_PWR_EN)  | (DATA_W'(1) << B_LED_A)   |
        (DATA_W'(1) << B_LED_B)   | (DATA_W'(1) << B_ADAPT);

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_HELD  = 1'b1
    } flag_state_t;
endpackage

// File: rtl/setclr_sync.sv
module setclr_sync #(
    parameter int STAGES = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain_q[s] <= RST_VAL;
                else if (s == 0)
                    chain_q[s] <= d_i;
                else
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/setclr_flag.sv
module setclr_flag
    import setclr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic rearm_i,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (event_i) state_d = FLAG_HELD;       // capture
            FLAG_HELD:  if (rearm_i && !event_i) state_d = FLAG_CLEAR; // rearm
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FLAG_CLEAR;
        else
            state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q == FLAG_HELD);
    end
endmodule

// File: rtl/setclr_ctrl.sv
module setclr_ctrl
    import setclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hit_i,
    input  logic              clr_hit_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] ctrl_o
);
    logic [DATA_W-1:0] ctrl_q, set_v, clr_v;

    always_comb begin
        set_v = set_hit_i ? (mask_i & CTRL_MASK) : '0;
        clr_v = clr_hit_i ? (mask_i & CTRL_MASK) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= (ctrl_q | set_v) & ~clr_v;
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/setclr_ctrl_status.sv
module setclr_ctrl_status
    import setclr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tgt_rst_o,
    output logic              tap_rst_o,
    output logic              tgt_pwr_en_o,
    output logic [1:0]        led_o,
    output logic              adaptive_clk_sel_o,
    input  logic              tgt_rst_sense_n_i,
    input  logic              pwr_drop_i,
    input  logic              rclk_timeout_i
);
    localparam int FLAG_POS [N_FLAGS] = '{B_RST_SEEN, B_PWR_DROP, B_RCLK_TO};

    logic              set_hit, clr_hit;
    logic [DATA_W-1:0] ctrl_w, status_w;
    logic [N_EXT-1:0]  ext_raw, ext_sync;
    logic [N_FLAGS-1:0] flag_evt, flag_rearm, sticky_q;

    assign set_hit = bus_wr && (bus_addr == OFS_SET);
    assign clr_hit = bus_wr && (bus_addr == OFS_CLR);

    setclr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_hit_i (set_hit),
        .clr_hit_i (clr_hit),
        .mask_i    (bus_wdata),
        .ctrl_o    (ctrl_w)
    );

    // event levels of the external senses, active high
    assign ext_raw = {pwr_drop_i, ~tgt_rst_sense_n_i};

    generate
        for (genvar e = 0; e < N_EXT; e++) begin : g_ext
            setclr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (ext_raw[e]),
                .q_o   (ext_sync[e])
            );
            assign flag_evt[e]   = ext_sync[e];
            assign flag_rearm[e] = set_hit && bus_wdata[FLAG_POS[e]];
        end
    endgenerate

    assign flag_evt[2]   = rclk_timeout_i;
    assign flag_rearm[2] = clr_hit && bus_wdata[B_RCLK_TO];

    generate
        for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
            setclr_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .event_i (flag_evt[f]),
                .rearm_i (flag_rearm[f]),
                .flag_o  (sticky_q[f])
            );
        end
    endgenerate

    always_comb begin
        status_w = '0;
        for (int f = 0; f < N_FLAGS; f++)
            status_w[FLAG_POS[f]] = sticky_q[f];
    end

    always_comb begin
        bus_rdata = (bus_addr == OFS_SET) ? (ctrl_w | status_w) : '0;
    end

    always_comb begin
        tgt_rst_o          = ctrl_w[B_TGT_RST];
        tap_rst_o          = ctrl_w[B_TAP_RST];
        tgt_pwr_en_o       = ctrl_w[B_PWR_EN];
        led_o              = {ctrl_w[B_LED_B], ctrl_w[B_LED_A]};
        adaptive_clk_sel_o = ctrl_w[B_ADAPT];
    end
endmodule

// File: rtl/setclr_ctrl_status_chk.sv
module setclr_ctrl_status_chk
    import setclr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tgt_rst_o,
    input logic              tap_rst_o,
    input logic              tgt_pwr_en_o,
    input logic [1:0]        led_o,
    input logic              adaptive_clk_sel_o,
    input logic              rclk_timeout_i,
    input logic [N_FLAGS-1:0] sticky_q
);
    logic set_w, clr_w, other_w;
    assign set_w   = bus_wr && (bus_addr == OFS_SET);
    assign clr_w   = bus_wr && (bus_addr == OFS_CLR);
    assign other_w = bus_wr && !set_w && !clr_w;

    p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_w && bus_wdata[B_TGT_RST] |=> tgt_rst_o);

    p_clr_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w && bus_wdata[B_TAP_RST] |=> !tap_rst_o);

    p_other_ofs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        other_w |=> $stable({tgt_rst_o, tap_rst_o, tgt_pwr_en_o, led_o, adaptive_clk_sel_o}));

    p_rclk_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rclk_timeout_i |=> sticky_q[2]);

    p_rclk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_q[2] && !(clr_w && bus_wdata[B_RCLK_TO]) |=> sticky_q[2]);

    p_rearm_keeps_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_w && (bus_wdata & CTRL_MASK) == '0 |=> $stable({tgt_rst_o, tap_rst_o, tgt_pwr_en_o, led_o, adaptive_clk_sel_o}));
endmodule

bind setclr_ctrl_status setclr_ctrl_status_chk i_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .bus_addr           (bus_addr),
    .bus_wr             (bus_wr),
    .bus_wdata          (bus_wdata),
    .tgt_rst_o          (tgt_rst_o),
    .tap_rst_o          (tap_rst_o),
    .tgt_pwr_en_o       (tgt_pwr_en_o),
    .led_o              (led_o),
    .adaptive_clk_sel_o (adaptive_clk_sel_o),
    .rclk_timeout_i     (rclk_timeout_i),
    .sticky_q           (sticky_q)
);

// File: tb/test_setclr_ctrl_status.sv
`timescale 1ns/1ps
module test_setclr_ctrl_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tgt_rst_o, tap_rst_o, tgt_pwr_en_o, adaptive_clk_sel_o;
    logic [1:0]  led_o;
    logic        tgt_rst_sense_n_i = 1'b1;
    logic        pwr_drop_i = 1'b0;
    logic        rclk_timeout_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    setclr_ctrl_status i_setclr_ctrl_status (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_rst_o(tgt_rst_o),
        .tap_rst_o(tap_rst_o), .tgt_pwr_en_o(tgt_pwr_en_o), .led_o(led_o),
        .adaptive_clk_sel_o(adaptive_clk_sel_o),
        .tgt_rst_sense_n_i(tgt_rst_sense_n_i), .pwr_drop_i(pwr_drop_i),
        .rclk_timeout_i(rclk_timeout_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one write; inputs change at negedge, result sampled at following negedge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; bus_addr = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    function automatic logic [31:0] out_word();
        return {23'd0, adaptive_clk_sel_o, 2'b00, led_o, tgt_pwr_en_o, 1'b0, tap_rst_o, tgt_rst_o};
    endfunction

    task automatic t_reset();
        logic [31:0] r;
        bus_read(8'h10, r);
        check("R1 read", r, 32'h0);
        check("R1 outputs", out_word(), 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] r;
        bus_write(8'h10, 32'h0000_0011);
        bus_read(8'h10, r);
        check("R2 set mask", r, 32'h0000_0011);
        bus_write(8'h10, 32'h0000_010A);
        bus_read(8'h10, r);
        check("R2 set keeps others", r, 32'h0000_011B);
        check("R4 pin map", out_word(), 32'h0000_011B);
        check("R4 led", {30'd0, led_o}, 32'h1);
        bus_write(8'h14, 32'h0000_0101);
        bus_read(8'h10, r);
        check("R3 clear mask", r, 32'h0000_001A);
        check("R4 adaptive off", {31'd0, adaptive_clk_sel_o}, 32'h0);
        bus_write(8'h10, 32'h0000_0020);
        check("R4 led b", {30'd0, led_o}, 32'h3);
        bus_read(8'h14, r);
        check("R5 other offset reads zero", r, 32'h0);
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h10, r);
        check("R3 clear all", r, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] r;
        bus_write(8'h10, 32'h0000_0009);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FA04);
        bus_read(8'h10, r);
        check("R10 ignored writes", r, 32'h0000_0009);
        bus_write(8'h14, 32'h0000_00C0);
        bus_read(8'h10, r);
        check("R10 clear of 6/7 ignored", r, 32'h0000_0009);
        bus_write(8'h14, 32'h0000_0009);
    endtask

    task automatic t_sense();
        logic [31:0] r;
        @(negedge clk);
        tgt_rst_sense_n_i = 1'b0;
        @(negedge clk); @(negedge clk);
        bus_read(8'h10, r);
        check("R6 not before 3 edges", r, 32'h0);
        @(negedge clk);
        bus_read(8'h10, r);
        check("R6 reset seen", r, 32'h0000_0040);
        tgt_rst_sense_n_i = 1'b1;
        pwr_drop_i = 1'b1;
        repeat (3) @(negedge clk);
        pwr_drop_i = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(8'h10, r);
        check("R6 R7 sticky", r, 32'h0000_00C0);
        bus_write(8'h10, 32'h0000_0040);
        bus_read(8'h10, r);
        check("R8 rearm gone", r, 32'h0000_0080);
        check("R8 no control change", out_word(), 32'h0);
        pwr_drop_i = 1'b1;
        repeat (3) @(negedge clk);
        bus_write(8'h10, 32'h0000_0080);
        bus_read(8'h10, r);
        check("R8 rearm still present", r, 32'h0000_0080);
        pwr_drop_i = 1'b0;
        repeat (3) @(negedge clk);
        bus_write(8'h10, 32'h0000_0080);
        bus_read(8'h10, r);
        check("R7 cleared after rearm", r, 32'h0);
    endtask

    task automatic t_rclk();
        logic [31:0] r;
        @(negedge clk);
        rclk_timeout_i = 1'b1;
        @(negedge clk);
        rclk_timeout_i = 1'b0;
        bus_read(8'h10, r);
        check("R9 capture", r, 32'h0000_0400);
        bus_write(8'h10, 32'h0000_0400);
        bus_read(8'h10, r);
        check("R10 set of bit 10 ignored", r, 32'h0000_0400);
        @(negedge clk);
        bus_addr = 8'h14; bus_wr = 1'b1; bus_wdata = 32'h0000_0400; rclk_timeout_i = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; rclk_timeout_i = 1'b0;
        bus_read(8'h10, r);
        check("R9 capture beats clear", r, 32'h0000_0400);
        bus_write(8'h14, 32'h0000_0400);
        bus_read(8'h10, r);
        check("R9 cleared", r, 32'h0);
    endtask

    task automatic t_rst_again();
        logic [31:0] r;
        bus_write(8'h10, 32'h0000_013B);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        bus_read(8'h10, r);
        check("R1 reset clears", r, 32'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_set_clear();
                t_ignored();
                t_sense();
                t_rclk();
                t_rst_again();
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule